// File: doc/BRIEF.md
# I2C Register Target with Saturating Word Pointer

This block is an I2C target that lets a host reach a bank of 16-bit registers through a 10-bit address pointer. SCL and SDA are sampled on the system clock through short synchroniser chains. Edge detection on the synchronised lines finds START, repeated START and STOP conditions. The target answers to one group of 7-bit device addresses. A write transaction begins with two register-address bytes, which load the pointer. Any data bytes that follow are gathered into 16-bit words, most significant byte first. A read transaction returns words from the pointer onward, also high byte first.

The pointer advances after every word written or read, and it keeps its value across STOP. It never wraps. Once it reaches 0x3FF it stays there. Write data that arrives after the word at 0x3FF has been stored is dropped, and reads keep returning that last register. The register array is smaller than the address space. Addresses beyond its depth read as zero and ignore writes. SDA is driven open-drain style: an output enable pulls the line low.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a transaction from any state, including a repeated START with no STOP before it. A STOP (SDA rising while SCL is high) ends it.
- R2: The first byte after START is the device address in bits 7..1 and the R/W flag in bit 0, where 1 means read. The target matches when bits 7..3 equal 01011, whatever bits 2..1 hold. On a mismatch it gives no ACK and ignores the bus until the next START.
- R3: The target pulls SDA low during the ninth clock after a matched device address, after each register-address byte, and after each write data byte, including bytes that are later discarded.
- R4: The two bytes after a write device address form a register address, high byte first. Bits 9..0 load the pointer and bits 15..10 are ignored.
- R5: Write data bytes pair into words: the first byte of a pair is bits 15..8 and the second is bits 7..0. A word is stored only once both bytes have arrived. A trailing odd byte is dropped.
- R6: The pointer advances by one after each word stored and after each word read, and it keeps its value across STOP and repeated START.
- R7: The pointer saturates at 0x3FF. Once a word has been written at 0x3FF, further write data in that addressing is discarded. Reads at 0x3FF return register 0x3FF repeatedly.
- R8: A read sends the word at the pointer, bits 15..8 first, then bits 7..0 of that same word, MSB first within each byte.
- R9: When the host answers a read byte with NACK (SDA high on the ninth clock), the target stops sending and keeps SDA released until the next START.
- R10: After reset the target releases SDA (sda_oe = 0). It asserts sda_oe only while SCL is low, and it releases SDA on START and STOP.
- R11: With the default depth of 64, registers at addresses 64 and above read as 0x0000 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that the host keeps each SCL phase longer than the synchroniser delay plus one cycle. They also assume that SDA changes only while SCL is low, except for START and STOP. Under these conditions the synchronised SCL edge always comes before any SDA change that the host makes in the same phase. The stimulus holds each SCL half-period for ten system clocks and moves SDA five clocks into the low phase. A START or STOP is placed only during a high phase in which SDA changes. Because SDA in the bench is the wired-AND of the host and the target, the target also sees its own drive, just as it would on a real bus.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int IX_SDA = 0;
  localparam int IX_SCL = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prv;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= cur;
  end

  assign scl_s     = cur[IX_SCL];
  assign sda_s     = cur[IX_SDA];
  assign scl_rise  = cur[IX_SCL] & ~prv[IX_SCL];
  assign scl_fall  = ~cur[IX_SCL] & prv[IX_SCL];
  assign start_det = cur[IX_SCL] & prv[IX_SCL] & prv[IX_SDA] & ~cur[IX_SDA];
  assign stop_det  = cur[IX_SCL] & prv[IX_SCL] & ~prv[IX_SDA] & cur[IX_SDA];
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int PTR_W = 10,
  parameter int DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [PTR_W-1:0]               wr_addr,
  input  logic [i2c_reg_pkg::WORD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]               rd_addr,
  output logic [i2c_reg_pkg::WORD_W-1:0] rd_data
);
  import i2c_reg_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_q;
  logic              rd_ok_q;
  logic              wr_hit;

  assign wr_hit = wr_en && (wr_addr < DEPTH_L);

  always_ff @(posedge clk) begin
    if (wr_hit) mem[wr_addr[IDX_W-1:0]] <= wr_data;
    mem_q   <= mem[rd_addr[IDX_W-1:0]];
    rd_ok_q <= (rd_addr < DEPTH_L);
  end

  assign rd_data = rd_ok_q ? mem_q : '0;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm #(
  parameter int         PTR_W     = 10,
  parameter logic [4:0] DEV_MATCH = 5'b01011
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sda_s,
  input  logic                           scl_rise,
  input  logic                           scl_fall,
  input  logic                           start_det,
  input  logic                           stop_det,
  input  logic [i2c_reg_pkg::WORD_W-1:0] rd_data,
  output logic [PTR_W-1:0]               ptr,
  output logic                           ptr_load,
  output logic                           wr_en,
  output logic [PTR_W-1:0]               wr_addr,
  output logic [i2c_reg_pkg::WORD_W-1:0] wr_data,
  output logic                           sda_oe
);
  import i2c_reg_pkg::*;

  localparam int HI_W = PTR_W - BYTE_W;
  localparam logic [PTR_W-1:0] PTR_MAX = '1;
  localparam logic [3:0] BITS_DONE = 4'd8;

  tgt_state_e        state;
  rx_kind_e          kind;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [HI_W-1:0]   addr_hi;
  logic [BYTE_W-1:0] data_hi;
  logic              have_hi;
  logic              full_q;
  logic              rw_q;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] tx_lo_byte;
  logic              tx_lo;
  logic              nack_q;

  always_ff @(posedge clk) begin
    wr_en    <= 1'b0;
    ptr_load <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      kind       <= RX_DEV;
      bitcnt     <= '0;
      shreg      <= '0;
      addr_hi    <= '0;
      data_hi    <= '0;
      have_hi    <= 1'b0;
      full_q     <= 1'b0;
      rw_q       <= 1'b0;
      tx_sh      <= '0;
      tx_lo_byte <= '0;
      tx_lo      <= 1'b0;
      nack_q     <= 1'b0;
      ptr        <= '0;
      wr_addr    <= '0;
      wr_data    <= '0;
      sda_oe     <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      kind    <= RX_DEV;
      bitcnt  <= '0;
      have_hi <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      have_hi <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != BITS_DONE) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == BITS_DONE) begin
            bitcnt <= '0;
            state  <= ST_ACK;
            sda_oe <= 1'b1;
            unique case (kind)
              RX_DEV: begin
                if (shreg[7:3] == DEV_MATCH) begin
                  rw_q <= shreg[0];
                  kind <= RX_AHI;
                end else begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              RX_AHI: begin
                addr_hi <= shreg[HI_W-1:0];
                kind    <= RX_ALO;
              end
              RX_ALO: begin
                ptr      <= {addr_hi, shreg};
                ptr_load <= 1'b1;
                full_q   <= 1'b0;
                kind     <= RX_DATA;
              end
              RX_DATA: begin
                if (!have_hi) begin
                  data_hi <= shreg;
                  have_hi <= 1'b1;
                end else begin
                  have_hi <= 1'b0;
                  if (!full_q) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= {data_hi, shreg};
                    if (ptr == PTR_MAX) full_q <= 1'b1;
                    else                ptr    <= ptr + 1'b1;
                  end
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state      <= ST_TX;
              tx_lo      <= 1'b0;
              tx_sh      <= rd_data[15:8];
              tx_lo_byte <= rd_data[7:0];
              sda_oe     <= ~rd_data[15];
            end else begin
              state  <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == BITS_DONE) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_TXACK;
              if (tx_lo && ptr != PTR_MAX) ptr <= ptr + 1'b1;
            end else begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state <= ST_IDLE;
            end else if (!tx_lo) begin
              state  <= ST_TX;
              tx_lo  <= 1'b1;
              tx_sh  <= tx_lo_byte;
              sda_oe <= ~tx_lo_byte[7];
            end else begin
              state      <= ST_TX;
              tx_lo      <= 1'b0;
              tx_sh      <= rd_data[15:8];
              tx_lo_byte <= rd_data[7:0];
              sda_oe     <= ~rd_data[15];
            end
          end
        end
        default: begin
          bitcnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         PTR_W       = 10,
  parameter int         DEPTH       = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_MATCH   = 5'b01011
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_reg_pkg::*;

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [PTR_W-1:0]  ptr;
  logic              ptr_load;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.PTR_W(PTR_W), .DEV_MATCH(DEV_MATCH)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .ptr_load  (ptr_load),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_reg_array #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_arr (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  logic unused_scl_s;
  assign unused_scl_s = scl_s;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             stop_det,
  input logic [PTR_W-1:0] ptr,
  input logic             ptr_load,
  input logic             wr_en
);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  // R10: the pull-down only engages while SCL is low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R1: a STOP leaves SDA released
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R6: the pointer moves only by a load or a single step without wrap
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr) && !ptr_load) |-> ({1'b0, ptr} == {1'b0, $past(ptr)} + 1'b1));

  // R7: at the top the pointer stays put until reloaded
  assert_ptr_sat_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(ptr) == PTR_MAX && !ptr_load) |-> ptr == PTR_MAX);

  // R3: a word commit coincides with the ACK pull-down
  assert_commit_ack_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sda_oe);

  // R5: one commit per received byte pair
  assert_single_commit_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .stop_det (stop_det),
  .ptr      (ptr),
  .ptr_load (ptr_load),
  .wr_en    (wr_en)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int DEPTH = 64;
  localparam int PMAX  = 1023;
  localparam int WD    = 190000;
  localparam logic [6:0] DEV_A = 7'h2C;
  localparam logic [6:0] DEV_B = 7'h2F;
  localparam logic [6:0] DEV_X = 7'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe;
  bit   slave_turn = 1'b0;
  bit   done = 1'b0;
  int   checks = 0;
  int   fails = 0;

  logic [15:0] mmem [DEPTH];
  logic [15:0] wbuf [DEPTH];
  int   mptr = 0;
  bit   mfull = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_reg_target u_dut (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10: every clock, the target may pull SDA during SCL high only in its own slot
  always @(posedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (scl && sda_oe && !slave_turn) begin
        fails++;
        $display("FAIL R10 actual=%0h expected=%0h", sda_oe, 0);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_set(input logic [15:0] a);
    mptr = int'(a[9:0]);
    mfull = 1'b0;
  endtask

  task automatic m_wr(input logic [15:0] w);
    if (!mfull) begin
      if (mptr < DEPTH) mmem[mptr] = w;
      if (mptr == PMAX) mfull = 1'b1;
      else mptr++;
    end
  endtask

  task automatic m_rd(output logic [15:0] w);
    w = (mptr < DEPTH) ? mmem[mptr] : 16'h0000;
    if (mptr != PMAX) mptr++;
  endtask

  task automatic bit_cycle(input logic b, input bit slave, output logic seen);
    wclk(5);
    m_sda = b;
    slave_turn = slave;
    wclk(5);
    scl = 1'b1;
    wclk(5);
    seen = sda_bus;
    wclk(5);
    scl = 1'b0;
  endtask

  task automatic i2c_start();
    slave_turn = 1'b0;
    wclk(5);
    m_sda = 1'b1;
    wclk(5);
    scl = 1'b1;
    wclk(5);
    m_sda = 1'b0;
    wclk(5);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    slave_turn = 1'b0;
    wclk(5);
    m_sda = 1'b0;
    wclk(5);
    scl = 1'b1;
    wclk(5);
    m_sda = 1'b1;
    wclk(10);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic seen;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, seen);
    bit_cycle(1'b1, 1'b1, seen);
    chk(seen == !exp_ack, tag, seen, !exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit host_ack, input string tag);
    logic seen;
    logic [7:0] got;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, 1'b1, seen);
      got[i] = seen;
    end
    bit_cycle(host_ack ? 1'b0 : 1'b1, 1'b0, seen);
    chk(got == exp, tag, got, exp);
  endtask

  task automatic write_regs(input logic [6:0] dev, input logic [15:0] a, input int n);
    i2c_start();
    send_byte({dev, 1'b0}, 1'b1, "R3 dev ack");
    send_byte(a[15:8], 1'b1, "R3 addr hi ack");
    send_byte(a[7:0], 1'b1, "R4 addr lo ack");
    m_set(a);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k][15:8], 1'b1, "R3 data hi ack");
      send_byte(wbuf[k][7:0], 1'b1, "R5 data lo ack");
      m_wr(wbuf[k]);
    end
  endtask

  task automatic read_regs(input logic [6:0] dev, input int n, input string tag);
    logic [15:0] w;
    i2c_start();
    send_byte({dev, 1'b1}, 1'b1, "R2 read dev ack");
    for (int k = 0; k < n; k++) begin
      m_rd(w);
      recv_byte(w[15:8], 1'b1, tag);
      recv_byte(w[7:0], k != n - 1, tag);
    end
    wclk(3);
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic set_ptr(input logic [15:0] a);
    write_regs(DEV_A, a, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mmem[i] = 16'h0000;
    wclk(6);
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
    rst = 1'b0;
    wclk(6);

    // R6: fill the whole array in one transaction
    for (int k = 0; k < DEPTH; k++) wbuf[k] = 16'(k * 16'h0403 + 16'h0101);
    write_regs(DEV_A, 16'h0000, DEPTH);
    i2c_stop();

    // R4: upper six address bits ignored
    wbuf[0] = 16'h1234; wbuf[1] = 16'hABCD; wbuf[2] = 16'h0F0F; wbuf[3] = 16'h5555;
    write_regs(DEV_A, 16'hFC05, 4);
    i2c_stop();

    // R1 R2 R8: pointer set, repeated START, read with other low address bits
    set_ptr(16'h0005);
    read_regs(DEV_B, 3, "R8 R1 read after repeated start");

    // R6: pointer survives STOP
    read_regs(DEV_A, 1, "R6 pointer kept over stop");

    // R2: foreign address gets no ACK and writes nothing
    i2c_start();
    send_byte({DEV_X, 1'b0}, 1'b0, "R2 mismatch nack");
    send_byte(8'h00, 1'b0, "R2 ignored byte");
    send_byte(8'h05, 1'b0, "R2 ignored byte");
    send_byte(8'h99, 1'b0, "R2 ignored byte");
    i2c_stop();
    set_ptr(16'h0005);
    i2c_stop();
    read_regs(DEV_A, 1, "R2 register untouched");

    // R5: odd trailing byte dropped
    i2c_start();
    send_byte({DEV_A, 1'b0}, 1'b1, "R3 dev ack");
    send_byte(8'h00, 1'b1, "R3 addr hi ack");
    send_byte(8'h10, 1'b1, "R3 addr lo ack");
    m_set(16'h0010);
    send_byte(8'h11, 1'b1, "R5 data ack");
    send_byte(8'h22, 1'b1, "R5 data ack");
    m_wr(16'h1122);
    send_byte(8'h33, 1'b1, "R5 odd byte ack");
    i2c_stop();
    set_ptr(16'h0010);
    read_regs(DEV_A, 2, "R5 odd byte dropped");

    // R7: write at top does not wrap into register 0
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222;
    write_regs(DEV_A, 16'h03FF, 2);
    i2c_stop();
    set_ptr(16'h0000);
    read_regs(DEV_A, 1, "R7 no write wrap");

    // R7: reads stay at the top
    set_ptr(16'h03FE);
    read_regs(DEV_A, 3, "R7 read saturation");
    read_regs(DEV_A, 1, "R7 still at top");

    // R11: beyond depth
    wbuf[0] = 16'h7777;
    write_regs(DEV_A, 16'h0040, 1);
    i2c_stop();
    set_ptr(16'h0040);
    read_regs(DEV_A, 1, "R11 out of depth zero");
    set_ptr(16'h003F);
    read_regs(DEV_A, 2, "R11 edge of depth");

    // R1: repeated START between two writes
    wbuf[0] = 16'hAAAA;
    write_regs(DEV_A, 16'h0020, 1);
    wbuf[0] = 16'hBBBB;
    write_regs(DEV_A, 16'h0021, 1);
    i2c_stop();
    set_ptr(16'h0020);
    read_regs(DEV_A, 2, "R1 write then repeated start write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule